// File: doc/BRIEF.md
# Ping-Pong DMA Channel Controller

This block is a single DMA channel that streams words to or from memory through two hardware buffer descriptors, A and B, used in alternation. Each descriptor holds a start address and a remaining beat count. Software programs the channel through eight word registers. A single status register can be reached through three aliases: one that sets bits, one that clears bits, and one that reads them. While one buffer is running, software can refill the idle descriptor and mark it started. When the active buffer runs out, the channel moves on to the other buffer in the same clock cycle.

Every beat is a word request on a request/acknowledge memory port. The address rises by 4 on each accepted beat. When a buffer drains, the channel raises that buffer's done flag and flips the buffer-in-use indicator. An interrupt is raised while it is enabled and a done or error flag is pending. An error response freezes the channel until software clears the error flag.

The control state machine has three states:
- `ST_IDLE`: no beat in flight. It moves to `ST_XFER` when run is set, error is clear and the current buffer's start bit is set. If only the other buffer's start bit is set, it first flips the buffer-in-use bit. It moves to `ST_HALT` when the error flag is set.
- `ST_XFER`: beats are requested for the current buffer.
  - When the last beat is acknowledged, or the count is already zero, the buffer completes.
  - On completion the machine stays in `ST_XFER` if the other buffer is started and run is still set. Otherwise it returns to `ST_IDLE`.
  - An acknowledged beat with run cleared returns it to `ST_IDLE`.
  - An error response moves it to `ST_HALT`.
- `ST_HALT`: it returns to `ST_IDLE` once software clears the error flag.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, the status register reads 0, `irq` is low, `mem_req` is low, and the configuration and descriptor registers read 0.
- R2: Registers are selected by word index as follows:
  - 0: configuration;
  - 1: status-set alias;
  - 2: status-clear alias;
  - 3: status read;
  - 4: address A;
  - 5: count A;
  - 6: address B;
  - 7: count B.

  The configuration register and the descriptors read back what was written; a count reads back its low CW bits. `mem_wr` equals configuration bit 0.
- R3: The status bits are:
  - bit 0: run;
  - bit 1: interrupt enable;
  - bit 2: error;
  - bit 3: done A;
  - bit 4: start A;
  - bit 5: done B;
  - bit 6: start B;
  - bit 7: buffer-in-use, set meaning B.

  A 1 written to index 1 sets bits 0–6, and a 1 written to index 2 clears them. Zero bits leave the status unchanged. Bit 7 cannot be written by either alias.
- R4: Each beat presents the current descriptor address. An acknowledged beat without error adds 4 to that address and subtracts 1 from its count. An unacknowledged request stays asserted with a stable address.
- R5: When the current buffer's count reaches zero, its start bit clears, its done bit sets and buffer-in-use toggles. After A completes, bit 7 reads 1; after B completes, it reads 0.
- R6: If the other buffer is started when one completes, its first beat is accepted in the cycle right after the last beat of the completing buffer.
- R7: With run set and both start bits clear, no request is issued.
- R8: `irq` equals interrupt enable AND (done A OR done B OR error).
- R9: Writing 1s to done positions through the clear alias clears them and drops `irq`.
- R10: Clearing run lets the beat in flight finish, then issues no further request. The descriptor keeps its progress, and setting run again resumes from there.
- R11: An acknowledge with error sets the error bit and is not counted as a beat. No further request is issued until software clears the error bit; the channel then retries the same address.
- R12: When a buffer completes in the same cycle that software clears its done bit, the done bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| mem_req | output | 1 | Beat request |
| mem_addr | output | AW | Beat address |
| mem_wr | output | 1 | Transfer direction, from configuration bit 0 |
| mem_ack | input | 1 | Beat accepted |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| irq | output | 1 | Interrupt |

## Verification
Two pairs of events can fall in the same cycle:
- A buffer completing while software writes the clear alias to remove that buffer's done bit. The bench issues three back-to-back register writes so that the third lands on the clock edge that accepts the final beat. The done bit must then still read 1 and `irq` must stay high.
- The last beat of one buffer and the first beat of the other. The other buffer is marked started while the first is running, and the bench records the cycle of every acknowledged beat. The cycle numbers of the two beats must differ by exactly one.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
    localparam int REG_W      = 32;
    localparam int STS_W      = 8;
    localparam int BEAT_BYTES = 4;

    // status bit positions
    localparam int B_RUN  = 0;
    localparam int B_IE   = 1;
    localparam int B_ERR  = 2;
    localparam int B_DNA  = 3;
    localparam int B_STA  = 4;
    localparam int B_DNB  = 5;
    localparam int B_STB  = 6;
    localparam int B_BIU  = 7;

    localparam logic [STS_W-1:0] SW_MASK = 8'h7F;

    // register word indices
    localparam logic [2:0] IDX_CFG  = 3'd0;
    localparam logic [2:0] IDX_SET  = 3'd1;
    localparam logic [2:0] IDX_CLR  = 3'd2;
    localparam logic [2:0] IDX_STS  = 3'd3;
    localparam logic [2:0] IDX_DESC = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HALT = 2'd2
    } chan_state_e;

    function automatic int unsigned start_pos(logic b);
        return b ? B_STB : B_STA;
    endfunction

    function automatic int unsigned done_pos(logic b);
        return b ? B_DNB : B_DNA;
    endfunction
endpackage

// File: rtl/pp_dma_desc.sv
module pp_dma_desc #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          step,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] cnt_o
);
    import pp_dma_pkg::*;

    localparam logic [AW-1:0] ADDR_INC = AW'(BEAT_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            cnt_o  <= '0;
        end else begin
            // a software write wins over engine progress
            if (addr_we)   addr_o <= addr_wdata;
            else if (step) addr_o <= addr_o + ADDR_INC;
            if (cnt_we)    cnt_o  <= cnt_wdata;
            else if (step) cnt_o  <= cnt_o - CW'(1);
        end
    end
endmodule

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl #(
    parameter int CW = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [pp_dma_pkg::STS_W-1:0] set_mask,
    input  logic [pp_dma_pkg::STS_W-1:0] clr_mask,
    input  logic [CW-1:0]                cnt_a,
    input  logic [CW-1:0]                cnt_b,
    input  logic                         mem_ack_i,
    input  logic                         mem_err_i,
    output logic [pp_dma_pkg::STS_W-1:0] status_o,
    output logic                         cur_o,
    output logic                         mem_req_o,
    output logic [1:0]                   step_o,
    output logic                         irq_o
);
    import pp_dma_pkg::*;

    chan_state_e        state_q, state_d;
    logic [STS_W-1:0]   sts_q, sts_d, sts_sw;
    logic               cur;
    logic [CW-1:0]      cur_cnt;
    logic               fin;

    assign cur     = sts_q[B_BIU];
    assign cur_cnt = cur ? cnt_b : cnt_a;
    assign sts_sw  = (sts_q | (set_mask & SW_MASK)) & ~(clr_mask & SW_MASK);

    // state and status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sts_q   <= '0;
        end else begin
            state_q <= state_d;
            sts_q   <= sts_d;
        end
    end

    // next state; hardware events are applied after software writes
    always_comb begin
        sts_d   = sts_sw;
        state_d = state_q;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sts_q[B_ERR]) begin
                    state_d = ST_HALT;
                end else if (sts_q[B_RUN]) begin
                    if (sts_q[start_pos(cur)]) begin
                        state_d = ST_XFER;
                    end else if (sts_q[start_pos(!cur)]) begin
                        sts_d[B_BIU] = !cur;
                        state_d      = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (cur_cnt == '0) begin
                    fin = 1'b1;
                end else if (mem_ack_i) begin
                    if (mem_err_i) begin
                        sts_d[B_ERR] = 1'b1;
                        state_d      = ST_HALT;
                    end else if (cur_cnt == CW'(1)) begin
                        fin = 1'b1;
                    end else if (!sts_sw[B_RUN] || sts_sw[B_ERR]) begin
                        state_d = ST_IDLE;
                    end
                end
                if (fin) begin
                    sts_d[start_pos(cur)] = 1'b0;
                    sts_d[done_pos(cur)]  = 1'b1;
                    sts_d[B_BIU]          = !cur;
                    if (sts_sw[B_RUN] && !sts_sw[B_ERR] && sts_sw[start_pos(!cur)])
                        state_d = ST_XFER;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (!sts_q[B_ERR]) state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        mem_req_o = (state_q == ST_XFER) && (cur_cnt != '0);
        step_o[0] = mem_req_o && mem_ack_i && !mem_err_i && !cur;
        step_o[1] = mem_req_o && mem_ack_i && !mem_err_i && cur;
        irq_o     = sts_q[B_IE] && (sts_q[B_DNA] || sts_q[B_DNB] || sts_q[B_ERR]);
        status_o  = sts_q;
        cur_o     = cur;
    end
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_idx,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          irq
);
    import pp_dma_pkg::*;

    localparam int NBUF = 2;

    logic [REG_W-1:0] cfg_q;
    logic [STS_W-1:0] status_w, set_w, clr_w;
    logic [AW-1:0]    d_addr [NBUF];
    logic [CW-1:0]    d_cnt  [NBUF];
    logic [1:0]       step_w;
    logic             cur_w;

    always_ff @(posedge clk) begin
        if (!rst_n)                             cfg_q <= '0;
        else if (reg_we && reg_idx == IDX_CFG)  cfg_q <= reg_wdata;
    end

    assign set_w  = (reg_we && reg_idx == IDX_SET) ? reg_wdata[STS_W-1:0] : '0;
    assign clr_w  = (reg_we && reg_idx == IDX_CLR) ? reg_wdata[STS_W-1:0] : '0;
    assign mem_wr = cfg_q[0];

    for (genvar g = 0; g < NBUF; g++) begin : g_desc
        localparam logic [2:0] A_IDX = IDX_DESC + 3'(2 * g);
        localparam logic [2:0] C_IDX = IDX_DESC + 3'(2 * g + 1);
        pp_dma_desc #(.AW(AW), .CW(CW)) u_desc (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr_we    (reg_we && reg_idx == A_IDX),
            .addr_wdata (reg_wdata[AW-1:0]),
            .cnt_we     (reg_we && reg_idx == C_IDX),
            .cnt_wdata  (reg_wdata[CW-1:0]),
            .step       (step_w[g]),
            .addr_o     (d_addr[g]),
            .cnt_o      (d_cnt[g])
        );
    end

    pp_dma_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_mask  (set_w),
        .clr_mask  (clr_w),
        .cnt_a     (d_cnt[0]),
        .cnt_b     (d_cnt[1]),
        .mem_ack_i (mem_ack),
        .mem_err_i (mem_err),
        .status_o  (status_w),
        .cur_o     (cur_w),
        .mem_req_o (mem_req),
        .step_o    (step_w),
        .irq_o     (irq)
    );

    assign mem_addr = cur_w ? d_addr[1] : d_addr[0];

    always_comb begin
        unique case (reg_idx)
            3'd0:             reg_rdata = cfg_q;
            3'd1, 3'd2, 3'd3: reg_rdata = REG_W'(status_w);
            3'd4:             reg_rdata = REG_W'(d_addr[0]);
            3'd5:             reg_rdata = REG_W'(d_cnt[0]);
            3'd6:             reg_rdata = REG_W'(d_addr[1]);
            3'd7:             reg_rdata = REG_W'(d_cnt[1]);
        endcase
    end
endmodule

// File: rtl/pp_dma_chan_chk.sv
module pp_dma_chan_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    sts,
    input logic          irq,
    input logic          reg_we,
    input logic [2:0]    reg_idx
);
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_req_has_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (sts[4] || sts[6]));

    assert_biu_after_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[3]) && !$past(reg_we && reg_idx == 3'd1) |-> sts[7]);

    assert_biu_after_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[5]) && !$past(reg_we && reg_idx == 3'd1) |-> !sts[7]);

    assert_irq_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sts[1]);

    assert_stopped_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sts[0] && !mem_req |=> !mem_req);

    assert_err_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err |=> !mem_req && sts[2]);

    assert_err_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sts[2] && !mem_req |=> !mem_req);
endmodule

bind pp_dma_chan pp_dma_chan_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .mem_addr (mem_addr),
    .sts      (status_w),
    .irq      (irq),
    .reg_we   (reg_we),
    .reg_idx  (reg_idx)
);

// File: tb/pp_dma_chan_tb_top.sv
module pp_dma_chan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_idx = 3'd0;
    logic [31:0]   reg_wdata = 32'd0;
    logic [31:0]   reg_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_wr;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;
    logic          irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit err_arm = 1'b0;
    logic [31:0] exp_q[$];
    int beat_cyc[$];
    logic [31:0] cfg_val;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pp_dma_chan #(.AW(AW), .CW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_ack(mem_ack),
        .mem_err(mem_err), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // memory responder and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            mem_ack = 1'b1;
            if (err_arm) begin
                mem_err = 1'b1;
                err_arm = 1'b0;
            end else begin
                mem_err = 1'b0;
                beat_cyc.push_back(cyc);
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4: actual=beat at 0x%0h expected=no beat", mem_addr);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    if (mem_addr !== e) begin
                        errors++;
                        $display("FAIL R4: actual=0x%0h expected=0x%0h", mem_addr, e);
                    end
                end
            end
        end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
    end

    task automatic wr(logic [2:0] idx, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] idx, output logic [31:0] v);
        @(negedge clk);
        reg_idx = idx;
        #1 v = reg_rdata;
    endtask

    task automatic push_beats(logic [31:0] base, int n);
        for (int i = 0; i < n; i++) exp_q.push_back(base + 32'(4 * i));
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base, nb;
        wait_cyc(3);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd3, v); chk("R1 status", v, 32'h0);
        rd(3'd5, v); chk("R1 count A", v, 32'h0);
        rd(3'd0, v); chk("R1 config", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

        // R2 register block
        wr(3'd0, 32'h1234_56A5);
        rd(3'd0, v); chk("R2 config", v, 32'h1234_56A5);
        chk("R2 mem_wr set", {31'd0, mem_wr}, 32'd1);
        cfg_val = 32'h1234_56A4;
        wr(3'd0, cfg_val);
        chk("R2 mem_wr clear", {31'd0, mem_wr}, 32'd0);
        wr(3'd6, 32'hDEAD_0010);
        rd(3'd6, v); chk("R2 address B", v, 32'hDEAD_0010);
        wr(3'd7, 32'hFFFF_0009);
        rd(3'd7, v); chk("R2 count B low bits", v, 32'h0000_0009);

        // R3 set/clear aliases
        wr(3'd1, 32'h02); rd(3'd3, v); chk("R3 set ie", v, 32'h02);
        wr(3'd1, 32'h00); rd(3'd3, v); chk("R3 zero set", v, 32'h02);
        wr(3'd2, 32'h00); rd(3'd3, v); chk("R3 zero clear", v, 32'h02);
        wr(3'd1, 32'h80); rd(3'd3, v); chk("R3 bit7 not writable", v, 32'h02);
        wr(3'd2, 32'h02); rd(3'd3, v); chk("R3 clear ie", v, 32'h00);

        // R7 run without start
        nb = beat_cyc.size();
        wr(3'd1, 32'h01);
        wait_cyc(6);
        chk("R7 no beats", 32'(beat_cyc.size() - nb), 32'd0);
        rd(3'd3, v); chk("R7 status", v, 32'h01);
        wr(3'd2, 32'h01);

        // R4 R5 single buffer A
        wr(3'd4, 32'h100); wr(3'd5, 32'd3);
        push_beats(32'h100, 3);
        wr(3'd1, 32'h13);
        wait_cyc(8);
        chk("R4 all A beats", 32'(exp_q.size()), 32'd0);
        rd(3'd3, v); chk("R5 status after A", v, 32'h8B);
        rd(3'd5, v); chk("R4 count A drained", v, 32'd0);
        rd(3'd4, v); chk("R4 address A advanced", v, 32'h10C);
        chk("R8 irq on done", {31'd0, irq}, 32'd1);

        // R9 clear done bits
        wr(3'd2, 32'h28);
        rd(3'd3, v); chk("R9 done cleared", v, 32'h83);
        chk("R9 irq dropped", {31'd0, irq}, 32'd0);

        // R6 ping-pong B then A
        wr(3'd6, 32'h2000); wr(3'd7, 32'd2);
        wr(3'd4, 32'h3000); wr(3'd5, 32'd3);
        push_beats(32'h2000, 2); push_beats(32'h3000, 3);
        base = beat_cyc.size();
        wr(3'd1, 32'h40);
        wr(3'd1, 32'h10);
        wait_cyc(10);
        chk("R6 all beats", 32'(exp_q.size()), 32'd0);
        chk("R6 no gap", 32'(beat_cyc[base+2] - beat_cyc[base+1]), 32'd1);
        rd(3'd3, v); chk("R5 status after B then A", v, 32'hAB);
        wr(3'd2, 32'h28);

        // R8 interrupt enable gating
        wr(3'd2, 32'h02);
        wr(3'd6, 32'h4000); wr(3'd7, 32'd1);
        push_beats(32'h4000, 1);
        wr(3'd1, 32'h40);
        wait_cyc(6);
        rd(3'd3, v); chk("R5 status after B", v, 32'h21);
        chk("R8 irq masked", {31'd0, irq}, 32'd0);
        wr(3'd1, 32'h02);
        chk("R8 irq enabled", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'h20);
        chk("R8 irq after clear", {31'd0, irq}, 32'd0);

        // R12 completion coincides with clear of done
        wr(3'd4, 32'h5000); wr(3'd5, 32'd1);
        push_beats(32'h5000, 1);
        wr(3'd1, 32'h10);
        wr(3'd0, cfg_val);
        wr(3'd2, 32'h28);
        wait_cyc(3);
        rd(3'd3, v); chk("R12 done survives clear", v, 32'h8B);
        chk("R12 irq kept", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'h08);
        rd(3'd3, v); chk("R9 later clear works", v, 32'h83);

        // R10 run cleared mid-buffer
        wr(3'd6, 32'h6000); wr(3'd7, 32'd4);
        push_beats(32'h6000, 1);
        wr(3'd1, 32'h40);
        wr(3'd2, 32'h01);
        wait_cyc(6);
        chk("R10 one beat only", 32'(exp_q.size()), 32'd0);
        chk("R10 no request", {31'd0, mem_req}, 32'd0);
        rd(3'd7, v); chk("R10 count kept", v, 32'd3);
        rd(3'd6, v); chk("R10 address kept", v, 32'h6004);
        rd(3'd3, v); chk("R10 status stopped", v, 32'hC2);
        push_beats(32'h6004, 3);
        wr(3'd1, 32'h01);
        wait_cyc(8);
        chk("R10 resumed beats", 32'(exp_q.size()), 32'd0);
        rd(3'd3, v); chk("R10 status resumed", v, 32'h23);
        wr(3'd2, 32'h20);

        // R11 error response
        wr(3'd4, 32'h7000); wr(3'd5, 32'd2);
        err_arm = 1'b1;
        wr(3'd1, 32'h10);
        wait_cyc(6);
        rd(3'd3, v); chk("R11 error status", v, 32'h17);
        chk("R11 irq on error", {31'd0, irq}, 32'd1);
        chk("R11 halted", {31'd0, mem_req}, 32'd0);
        rd(3'd5, v); chk("R11 count unchanged", v, 32'd2);
        push_beats(32'h7000, 2);
        wr(3'd2, 32'h04);
        wait_cyc(8);
        chk("R11 retried beats", 32'(exp_q.size()), 32'd0);
        rd(3'd3, v); chk("R11 status after retry", v, 32'h8B);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule